// File: doc/BRIEF.md
# Bit-Matrix Product Unit

This block multiplies two 8x8 bit matrices, each packed into a 64-bit word with byte r holding row r. Every output bit (r, c) combines row r of the left matrix with column c of the right matrix through a bitwise AND. It then reduces the eight AND terms in one of three ways: parity (a product over GF(2), with an 8-bit affine constant XORed into every row), any-bit-set (OR of the terms) or all-bits-set (AND of the terms). The right matrix is transposed inside the block, so its columns line up with the rows of the left matrix.

Operands arrive on a valid/ready stream and results leave on another. The product itself is combinational and is captured in one output register. A transfer on the input side happens on a rising clock edge when `in_valid` and `in_ready` are both high. The result is shown on the output side from the next cycle and stays there, unchanged, until `out_ready` takes it. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back operations run at one per clock while the consumer keeps `out_ready` high.

Top module: `bitmat_mul`

## Requirements
- R1: After reset, `out_valid` is 0 until an input transfer has taken place.
- R2: With `in_op` = 0 (parity), result bit r*8+c equals bit c of `in_k` XOR the parity of the eight terms `in_a[r*8+j] & in_b[j*8+c]`, for j from 0 to 7. With `in_k` = 0xff every result bit is the inverted parity.
- R3: With `in_op` = 0, `in_k` = 0 and `in_b` equal to the identity matrix 0x8040201008040201, the result equals `in_a`.
- R4: With `in_op` = 1 (any), result bit r*8+c is 1 exactly when at least one of the eight terms `in_a[r*8+j] & in_b[j*8+c]` is 1.
- R5: With `in_op` = 2 (all), result bit r*8+c is 1 exactly when all eight of those terms are 1.
- R6: With `in_op` = 3, every result bit is 0.
- R7: An input transfer takes place on a clock edge where `in_valid` and `in_ready` are both 1, and `out_valid` is 1 in the next cycle. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_m` hold their values into the next cycle.
- R9: In the any and all modes `in_k` has no effect: the same matrices give the same result whatever the constant.
- R10: Results leave in the order their operands were accepted, one result for each transfer, and `out_valid` falls after a drain edge that brings no new input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present |
| in_ready | output | 1 | Block can take operands this cycle |
| in_a | input | 64 | Left matrix, byte r is row r |
| in_b | input | 64 | Right matrix, byte r is row r |
| in_k | input | 8 | Affine constant for parity mode |
| in_op | input | 2 | 0 parity, 1 any, 2 all, 3 zero |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_m | output | 64 | Result matrix, byte r is row r |

## Verification
The properties assume that the operand and mode pins carry known values in every cycle where `in_valid` is high. They also assume that the consumer may lower `out_ready` in any cycle, regardless of what it did before. The stimulus drives every operand field from defined values and sets them only between clock edges. It changes `out_ready` with a random pattern, so that results are both held back and drained back to back. The identity-matrix check covers only transfers whose right operand is exactly the identity and whose constant is zero. The stimulus sends such transfers both under stall and while the output drains freely.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;
  typedef enum logic [1:0] {
    OP_PARITY = 2'd0,
    OP_ANY    = 2'd1,
    OP_ALL    = 2'd2,
    OP_ZERO   = 2'd3
  } bm_op_e;

  // Unit matrix of a given dimension, row r carries bit r
  function automatic logic [63:0] unit_matrix(input int dim);
    logic [63:0] m;
    m = '0;
    for (int r = 0; r < dim; r++) m[r*dim + r] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bitmat_transpose.sv
module bitmat_transpose #(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign dst[c*DIM + r] = src[r*DIM + c];
    end
  end
endmodule

// File: rtl/bitmat_reduce.sv
module bitmat_reduce
  import bitmat_pkg::*;
#(
  parameter int DIM = 8
) (
  input  logic [DIM-1:0] row,
  input  logic [DIM-1:0] col,
  input  bm_op_e         op,
  input  logic           kbit,
  output logic           bit_o
);
  logic [DIM-1:0] terms;
  assign terms = row & col;

  always_comb begin
    unique case (op)
      OP_PARITY: bit_o = (^terms) ^ kbit;
      OP_ANY:    bit_o = |terms;
      OP_ALL:    bit_o = &terms;
      default:   bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitmat_core.sv
module bitmat_core
  import bitmat_pkg::*;
#(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic [W-1:0]   mat_a,
  input  logic [W-1:0]   mat_b,
  input  logic [DIM-1:0] kconst,
  input  bm_op_e         op,
  output logic [W-1:0]   mat_p
);
  logic [W-1:0] b_cols;

  bitmat_transpose #(.DIM(DIM)) u_tr (
    .src(mat_b),
    .dst(b_cols)
  );

  for (genvar r = 0; r < DIM; r++) begin : g_r
    for (genvar c = 0; c < DIM; c++) begin : g_c
      bitmat_reduce #(.DIM(DIM)) u_red (
        .row  (mat_a[r*DIM +: DIM]),
        .col  (b_cols[c*DIM +: DIM]),
        .op   (op),
        .kbit (kconst[c]),
        .bit_o(mat_p[r*DIM + c])
      );
    end
  end
endmodule

// File: rtl/bitmat_mul.sv
module bitmat_mul
  import bitmat_pkg::*;
#(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [DIM-1:0] in_k,
  input  logic [1:0]     in_op,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_m
);
  logic [W-1:0] prod;

  bitmat_core #(.DIM(DIM)) u_core (
    .mat_a (in_a),
    .mat_b (in_b),
    .kconst(in_k),
    .op    (bm_op_e'(in_op)),
    .mat_p (prod)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_m     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_m <= prod;
    end
  end
endmodule

// File: rtl/bitmat_mul_chk.sv
module bitmat_mul_chk
  import bitmat_pkg::*;
#(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic [DIM-1:0] in_k,
  input logic [1:0]     in_op,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   out_m
);
  logic take;
  assign take = in_valid && in_ready;

  // R7
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_m)));

  // R10
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R6
  zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == OP_ZERO) |=> (out_m == '0));

  // R3
  unit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == OP_PARITY && in_k == '0 && in_b == unit_matrix(DIM))
      |=> (out_m == $past(in_a)));
endmodule

bind bitmat_mul bitmat_mul_chk #(.DIM(DIM)) u_chk (.*);

// File: tb/bitmat_mul_test.sv
module bitmat_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [7:0]  in_k = '0;
  logic [1:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_m;

  int checks = 0;
  int fails = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        bp_on = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  bitmat_mul uut (.*);

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [7:0] k, input logic [1:0] op);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      int r = i / 8;
      int c = i % 8;
      int ones = 0;
      for (int j = 0; j < 8; j++) if (a[r*8+j] && b[j*8+c]) ones++;
      case (op)
        2'd0: m[i] = k[c] ^ ones[0];
        2'd1: m[i] = (ones != 0);
        2'd2: m[i] = (ones == 8);
        default: m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [7:0] k,
                      input logic [1:0] op, input string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_k = k; in_op = op; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(model(a, b, k, op));
    tag_q.push_back(tag);
    #1 in_valid = 1'b0;
  endtask

  // consumer ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #2 out_ready <= bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor: pops expected results as the design hands them out
  logic        held_v = 1'b0;
  logic [63:0] held_m;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) begin
        check("R8 valid", {63'd0, out_valid}, 64'd1);
        check("R8 data", out_m, held_m);
      end
      held_v = out_valid && !out_ready;
      held_m = out_m;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R10 extra", out_m, 64'hx);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_m, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] UNIT = 64'h8040201008040201;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {63'd0, out_valid}, 64'd0);
    check("R7 ready empty", {63'd0, in_ready}, 64'd1);

    for (int pass = 0; pass < 2; pass++) begin
      bp_on = (pass == 1);
      send(rnd64(), UNIT, 8'h00, 2'd0, "R3 unit");
      send(64'hdeadbeef01234567, UNIT, 8'h00, 2'd0, "R3 unit fixed");
      for (int n = 0; n < 10; n++) send(rnd64(), rnd64(), 8'($urandom()), 2'd0, "R2 parity");
      send(rnd64(), rnd64(), 8'hff, 2'd0, "R2 const ff");
      send(64'd0, rnd64(), 8'h5a, 2'd0, "R2 zero a");
      for (int n = 0; n < 8; n++) send(rnd64(), rnd64(), 8'h00, 2'd1, "R4 any");
      send(rnd64(), 64'd0, 8'h00, 2'd1, "R4 zero b");
      send(rnd64() | 64'h00000000ff000000, '1, 8'h00, 2'd2, "R5 full b");
      send('1, '1, 8'h00, 2'd2, "R5 all ones");
      for (int n = 0; n < 6; n++) send(rnd64() | rnd64(), rnd64() | rnd64(), 8'h00, 2'd2, "R5 all");
      send(rnd64(), rnd64(), 8'h3c, 2'd3, "R6 zero op");
      begin
        logic [63:0] a = rnd64();
        logic [63:0] b = rnd64();
        send(a, b, 8'h00, 2'd1, "R9 any k0");
        send(a, b, 8'hff, 2'd1, "R9 any kff");
        send(a | b, b, 8'h00, 2'd2, "R9 all k0");
        send(a | b, b, 8'ha5, 2'd2, "R9 all ka5");
      end
    end

    bp_on = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R10 drained", {63'd0, out_valid}, 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule